// File: doc/BRIEF.md
# Vertical Character Line Repeater

This block generates the vertical scan timing for a text overlay built from rows of character cells. After a rising edge on the vertical flyback input, it counts horizontal line strobes through a programmable vertical delay. It then walks 15 character rows. On each displayed scan line it reports which character row is active and which of the 18 font lines the pixel path should fetch.

A character cell holds 18 font lines. A 7-bit height code stretches the cell. The upper two bits pick a whole multiplier of the cell, so each font line appears once, twice or three times. Each of the five lower bits adds a fixed, evenly spread set of extra copies of particular font lines. Because of this, tall characters grow without a uniform divider. A double-height flag doubles every line's count. The output path samples the row and font-line indices only while the display-enable output is high.

Top module: `vchar_line_repeater`

## Requirements
- R1: While reset is low, and on the first cycle after it, disp_en is 0, row_idx is 0 and font_line is 0.
- R2: With D = 4*vdelay + 1, line strobes 1 to D-1 after a rising vsync edge leave disp_en at 0. Strobe number D raises disp_en with row_idx 0 and font_line 0. Outputs update on the clock edge that samples the strobe.
- R3: height_code[6:5] sets how often every font line is shown: 1 time for 00 or 01, 2 times for 10, 3 times for 11.
- R4: height_code[0], when height_code[4] is 0, shows font line 8 one extra time.
- R5: height_code[1] shows font lines 4 and 12 one extra time each.
- R6: height_code[2] shows font lines 2, 6, 10 and 14 one extra time each.
- R7: height_code[3] shows each odd font line from 1 to 15 one extra time.
- R8: height_code[4] alone shows font lines 1 to 16 one extra time each. With height_code[0] also set, the pair instead shows font lines 0 to 16 one extra time each, and line 8 gets no further copy.
- R9: dbl_height set doubles the number of times every font line is shown.
- R10: While disp_en is 1, each strobe advances the scan. The copies of a font line are consecutive. Font lines run 0 to 17 in order. row_idx steps after font line 17 and covers rows 0 to 14.
- R11: After the last copy of font line 17 of row 14, the next strobe drops disp_en. Further strobes leave disp_en at 0 until the next rising vsync edge. vsync held high is not a new edge.
- R12: A rising vsync edge at any time, including mid-frame, drops disp_en on the next clock and restarts the delay count of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | Vertical flyback level; its rising edge starts a frame |
| line_strobe | input | 1 | One-cycle pulse at the start of each horizontal line |
| vdelay | input | VD_W | Vertical delay setting; delay is 4*vdelay+1 lines |
| height_code | input | 7 | Character height code (multiplier in [6:5], weights in [4:0]) |
| dbl_height | input | 1 | Doubles every font line's count |
| disp_en | output | 1 | High on displayed scan lines |
| row_idx | output | ROW_W | Current character row |
| font_line | output | 5 | Font line to fetch, 0 to 17 |

## Verification
The hardest cases to reach from the ports are the exact line count that each weight adds and the pairing of bits 4 and 0, which redistributes extra copies instead of stacking them on line 8. A wrong mask bit alters only one font line in one row, deep into a frame. The stimulus therefore walks complete frames, one weight per frame, with a bench model of the repeat counts. It compares every scan line, so a single missing or extra copy shifts every later line and is reported. A mid-frame vsync edge and a vsync level held high cover restart behaviour.

// File: rtl/vrep_pkg.sv
// Shared constants and the font-line weight table for the vertical
// character line repeater. Assumes an 18-line character cell; the
// weight masks are defined for exactly that cell height.
package vrep_pkg;

    localparam int FONT_LINES = 18;
    localparam int LINE_W     = 5;
    localparam int REP_W      = 4;

    typedef enum logic [0:0] {
        SCAN_IDLE   = 1'b0,
        SCAN_ACTIVE = 1'b1
    } scan_state_t;

    // Returns which weights mark font line f for an extra copy.
    // Bit 0: weight 1, bit 1: weight 2, bit 2: weight 4, bit 3: weight 8,
    // bit 4: weight 16, bit 5: combined weight 17.
    function automatic logic [5:0] line_marks(input int f);
        logic [5:0] m;
        m[0] = (f == 8);
        m[1] = (f == 4) || (f == 12);
        m[2] = (f >= 2) && (f <= 14) && ((f % 4) == 2);
        m[3] = ((f % 2) == 1) && (f <= 15);
        m[4] = (f >= 1) && (f <= 16);
        m[5] = (f >= 0) && (f <= 16);
        return m;
    endfunction

endpackage

// File: rtl/vrep_delay.sv
// Detects the rising edge of the vertical flyback level and counts line
// strobes until the programmed vertical delay (4*vdelay + 1 lines) has
// elapsed, then issues a single start pulse. Assumes vsync is already
// synchronous to clk and line_strobe is a one-cycle pulse.
module vrep_delay #(
    parameter int VD_W = 8,
    localparam int CNT_W = VD_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vsync,
    input  logic            line_strobe,
    input  logic [VD_W-1:0] vdelay,
    output logic            restart,
    output logic            start
);

    logic             vsync_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_next;

    assign restart  = vsync & ~vsync_q;
    assign target   = {1'b0, vdelay, 2'b00} + CNT_W'(1);
    assign cnt_next = cnt_q + CNT_W'(1);
    assign start    = armed_q & line_strobe & ~restart & (cnt_next == target);

    // Keep the previous vsync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    // Count strobes after an edge; disarm once the delay expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (restart) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q && line_strobe) begin
            cnt_q   <= cnt_next;
        end
    end

    // R2
    start_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !start || (vdelay == '0));

endmodule

// File: rtl/vrep_weight.sv
// Computes how many scan lines the current font line occupies, from the
// height code and the double-height flag. One count per font line is
// built in a generate loop from the fixed weight masks, then selected.
// Assumes height_code and dbl_height are stable while a frame is shown.
module vrep_weight
    import vrep_pkg::*;
(
    input  logic [6:0]        height_code,
    input  logic              dbl_height,
    input  logic [LINE_W-1:0] font_line,
    output logic [REP_W-1:0]  rep_total
);

    logic [2:0] base;
    logic       pair;
    logic [2:0] raw [FONT_LINES];
    logic [2:0] sel;

    // Whole-cell multiplier from the two upper code bits.
    always_comb begin
        unique case (height_code[6:5])
            2'b10:   base = 3'd2;
            2'b11:   base = 3'd3;
            default: base = 3'd1;
        endcase
    end

    assign pair = height_code[4] & height_code[0];

    for (genvar g = 0; g < FONT_LINES; g++) begin : g_line
        localparam logic [5:0] MK = line_marks(g);
        assign raw[g] = base
                      + 3'(MK[0] & height_code[0] & ~pair)
                      + 3'(MK[1] & height_code[1])
                      + 3'(MK[2] & height_code[2])
                      + 3'(MK[3] & height_code[3])
                      + 3'(pair ? MK[5] : (MK[4] & height_code[4]));
    end

    // Pick the count for the current line; out-of-range lines fall back to line 0.
    always_comb begin
        if (font_line < LINE_W'(FONT_LINES)) sel = raw[font_line];
        else                                 sel = raw[0];
    end

    assign rep_total = dbl_height ? {sel, 1'b0} : {1'b0, sel};

endmodule

// File: rtl/vrep_scan.sv
// Walks the displayed part of a frame: repeat copies of one font line,
// font lines 0..17 of a row, then rows 0..NUM_ROWS-1. Goes idle after
// the last row until the next restart. Assumes start only follows restart.
module vrep_scan
    import vrep_pkg::*;
#(
    parameter int NUM_ROWS = 15,
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              start,
    input  logic              line_strobe,
    input  logic [REP_W-1:0]  rep_total,
    output logic              disp_en,
    output logic [ROW_W-1:0]  row_idx,
    output logic [LINE_W-1:0] font_line
);

    scan_state_t       state_q;
    logic [REP_W-1:0]  rep_q;
    logic [ROW_W-1:0]  row_q;
    logic [LINE_W-1:0] line_q;
    logic              last_copy;
    logic              last_line;
    logic              last_row;

    assign last_copy = ({1'b0, rep_q} + (REP_W+1)'(1)) >= {1'b0, rep_total};
    assign last_line = (line_q == LINE_W'(FONT_LINES - 1));
    assign last_row  = (row_q == ROW_W'(NUM_ROWS - 1));

    // Advance copy, font line and row counters on each displayed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= SCAN_IDLE;
            rep_q   <= '0;
            line_q  <= '0;
            row_q   <= '0;
        end else if (start) begin
            state_q <= SCAN_ACTIVE;
            rep_q   <= '0;
            line_q  <= '0;
            row_q   <= '0;
        end else if (state_q == SCAN_ACTIVE && line_strobe) begin
            if (!last_copy) begin
                rep_q <= rep_q + REP_W'(1);
            end else begin
                rep_q <= '0;
                if (!last_line) begin
                    line_q <= line_q + LINE_W'(1);
                end else begin
                    line_q <= '0;
                    if (last_row) begin
                        row_q   <= '0;
                        state_q <= SCAN_IDLE;
                    end else begin
                        row_q <= row_q + ROW_W'(1);
                    end
                end
            end
        end
    end

    assign disp_en   = (state_q == SCAN_ACTIVE);
    assign row_idx   = row_q;
    assign font_line = line_q;

    // R10
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (font_line < LINE_W'(FONT_LINES)));

    // R10
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (row_idx < ROW_W'(NUM_ROWS)));

    // R2
    first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> (row_idx == '0 && font_line == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe && !restart) |=> ($stable(disp_en) && $stable(row_idx) && $stable(font_line)));

    // R12
    restart_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !disp_en);

    // R3
    copy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (rep_q < rep_total));

endmodule

// File: rtl/vchar_line_repeater.sv
// Top of the vertical character line repeater: flyback edge and delay,
// per-line repeat count, and the row/font-line scan. Assumes line_strobe
// pulses once per horizontal line and vsync is synchronous to clk.
module vchar_line_repeater
    import vrep_pkg::*;
#(
    parameter int NUM_ROWS = 15,
    parameter int VD_W = 8,
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              line_strobe,
    input  logic [VD_W-1:0]   vdelay,
    input  logic [6:0]        height_code,
    input  logic              dbl_height,
    output logic              disp_en,
    output logic [ROW_W-1:0]  row_idx,
    output logic [LINE_W-1:0] font_line
);

    logic             restart;
    logic             start;
    logic [REP_W-1:0] rep_total;

    vrep_delay #(.VD_W(VD_W)) i_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync       (vsync),
        .line_strobe (line_strobe),
        .vdelay      (vdelay),
        .restart     (restart),
        .start       (start)
    );

    vrep_weight i_weight (
        .height_code (height_code),
        .dbl_height  (dbl_height),
        .font_line   (font_line),
        .rep_total   (rep_total)
    );

    vrep_scan #(.NUM_ROWS(NUM_ROWS)) i_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .start       (start),
        .line_strobe (line_strobe),
        .rep_total   (rep_total),
        .disp_en     (disp_en),
        .row_idx     (row_idx),
        .font_line   (font_line)
    );

endmodule

// File: tb/test_vchar_line_repeater.sv
module test_vchar_line_repeater;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       line_strobe = 1'b0;
    logic [7:0] vdelay = '0;
    logic [6:0] height_code = '0;
    logic       dbl_height = 1'b0;
    logic       disp_en;
    logic [3:0] row_idx;
    logic [4:0] font_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vchar_line_repeater i_vchar_line_repeater (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync       (vsync),
        .line_strobe (line_strobe),
        .vdelay      (vdelay),
        .height_code (height_code),
        .dbl_height  (dbl_height),
        .disp_en     (disp_en),
        .row_idx     (row_idx),
        .font_line   (font_line)
    );

    // Frame vectors: {vdelay[7:0], height_code[6:0], dbl_height}
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {8'd0, 7'b0000000, 1'b0},   // R2 R3 R10: plain 18-line cell
        {8'd2, 7'b0000001, 1'b0},   // R4: line 8 extra
        {8'd1, 7'b0000010, 1'b0},   // R5: lines 4, 12 extra
        {8'd3, 7'b0000100, 1'b0},   // R6: lines 2, 6, 10, 14 extra
        {8'd0, 7'b0001000, 1'b0},   // R7: odd lines extra
        {8'd1, 7'b0010000, 1'b0},   // R8: lines 1..16 extra
        {8'd0, 7'b0010001, 1'b0},   // R8: paired weight, lines 0..16 extra
        {8'd5, 7'b1000000, 1'b1},   // R3 R9: two copies, doubled
        {8'd0, 7'b1101111, 0},      // R3: three copies with several weights
        {8'd2, 7'b1110001, 1'b1}    // R9 R8: largest cell, doubled
    };

    function automatic int exp_count(logic [6:0] c, logic d, int f);
        int n;
        bit pr;
        pr = c[4] & c[0];
        n = c[6] ? (c[5] ? 3 : 2) : 1;
        if (c[0] && !pr && f == 8) n++;
        if (c[1] && (f == 4 || f == 12)) n++;
        if (c[2] && (f == 2 || f == 6 || f == 10 || f == 14)) n++;
        if (c[3] && (f % 2 == 1) && f <= 15) n++;
        if (pr) begin
            if (f <= 16) n++;
        end else if (c[4] && f >= 1 && f <= 16) begin
            n++;
        end
        return d ? 2 * n : n;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pos();
        return int'(disp_en) * 1000 + int'(row_idx) * 100 + int'(font_line);
    endfunction

    task automatic strobe();
        @(negedge clk) line_strobe = 1'b1;
        @(negedge clk) line_strobe = 1'b0;
    endtask

    task automatic vpulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
    endtask

    task automatic run_frame(logic [7:0] vd, logic [6:0] c, logic d, int idx);
        int dl;
        vdelay = vd; height_code = c; dbl_height = d;
        vpulse();
        chk(disp_en == 1'b0, "R12", $sformatf("vec %0d blank after edge", idx), pos(), 0);
        dl = 4 * int'(vd) + 1;
        for (int k = 1; k < dl; k++) begin
            strobe();
            chk(disp_en == 1'b0, "R2", $sformatf("vec %0d delay line %0d", idx, k), pos(), 0);
        end
        for (int r = 0; r < 15; r++) begin
            for (int f = 0; f < 18; f++) begin
                for (int n = 0; n < exp_count(c, d, f); n++) begin
                    strobe();
                    chk(pos() == 1000 + r * 100 + f, "R10",
                        $sformatf("vec %0d scan copy %0d (heights R3 R4 R5 R6 R7 R8 R9)", idx, n),
                        pos(), 1000 + r * 100 + f);
                end
            end
        end
        for (int k = 0; k < 3; k++) begin
            strobe();
            chk(disp_en == 1'b0, "R11", $sformatf("vec %0d idle after frame", idx), pos(), 0);
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < 200000; cyc++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset with strobes arriving
        line_strobe = 1'b1;
        @(negedge clk);
        chk(pos() == 0, "R1", "during reset", pos(), 0);
        line_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(pos() == 0, "R1", "after reset", pos(), 0);

        for (int i = 0; i < NV; i++)
            run_frame(VEC[i][15:8], VEC[i][7:1], VEC[i][0], i);

        // R12: edge mid-frame restarts the delay
        vdelay = 8'd1; height_code = 7'b0; dbl_height = 1'b0;
        vpulse();
        for (int k = 0; k < 8; k++) strobe();
        chk(pos() == 1003, "R12", "mid-frame position before edge", pos(), 1003);
        vpulse();
        chk(disp_en == 1'b0, "R12", "blank after mid-frame edge", pos(), 0);
        for (int k = 0; k < 4; k++) strobe();
        chk(disp_en == 1'b0, "R12", "delay restarted", pos(), 0);
        strobe();
        chk(pos() == 1000, "R12", "row 0 line 0 after restart", pos(), 1000);

        // R11: vsync held high is one edge only
        vdelay = 8'd3;
        @(negedge clk) vsync = 1'b1;
        for (int k = 0; k < 12; k++) strobe();
        chk(disp_en == 1'b0, "R2", "held-high delay", pos(), 0);
        for (int k = 0; k < 8; k++) strobe();
        chk(pos() == 1007, "R11", "held vsync no restart", pos(), 1007);
        @(negedge clk) vsync = 1'b0;

        // R1: reset mid-display
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk(pos() == 0, "R1", "reset mid-display", pos(), 0);
        rst_n = 1'b1;
        strobe();
        chk(pos() == 0, "R1", "no display without edge after reset", pos(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule